// File: doc/BRIEF.md
# Two-Stage Converter Power-Up Sequencer

This block is the digital supervisor for a controller that drives two power stages: a power-factor-correction stage that builds a bus voltage, and a flyback stage that runs from that bus. The analog comparators around the controller reduce the supply, mains and bus conditions to single-bit flags. The sequencer turns these flags and a pair of fault request pulses into enables for the start-up charge current, the latch-pin drive, the soft-start charging and the two gate drives.

Power-up is staged. The supply is first charged from the high-voltage path. The block then drives the latch pin and the soft-start nodes. The correction stage starts next, and the flyback starts once the bus is high enough. Until the flyback takes over the supply, the charge current holds the supply near its start level by hysteretic on/off control.

Faults are handled in three ways. A latched stop keeps both stages off until power is removed. A safe restart lets the supply sag and then repeats the whole power-up. A pause acts on the correction stage only. Every input flag passes through a two-flop synchronizer, so a flag change reaches the state register on the third rising edge after it is applied.

Top module: `startup_seq`

## Requirements
- R1: In the charge state, `chg_mode` is 01 (low) below the trip flag, 10 (high) between trip and lockout, and 01 again between lockout and the start flag. The encoding is 00 off, 01 low, 10 high.
- R2: When the start flag asserts in the charge state, the block enters an init state with `chg_mode` 00 and with `latch_drv` and `ss_chg` at 1.
- R3: The correction drive turns on only when `lat_ok` and `pfc_ss_ok` are both true in init. At that moment `chg_mode` becomes 10.
- R4: The flyback drive turns on, and `chg_mode` becomes 00, when `bus_start` is true while `fb_ss_ok` is true. `bus_start` alone does nothing.
- R5: While only the correction stage runs, the charge current switches off when the start flag is true and back to 10 when `vcc_hlo` falls. Between those two flags it keeps its value.
- R6: In init, loss of the lockout flag returns the block to charging. `latch_drv` goes to 0 and `chg_mode` goes to 10.
- R7: After the flyback has started, `ctrl_tmo` stops both drives and the latch and soft-start outputs, with `chg_mode` 00. When the lockout flag drops, recharge starts and the full power-up repeats.
- R8: A `flt_restart` pulse in init or in either run state causes the same safe restart as R7.
- R9: A `flt_latch` pulse stops everything. The supply is then recharged hysteretically: `chg_mode` 10 once the lockout flag drops, 00 once the start flag is true. The converters never restart.
- R10: `pfc_ovp` forces `pfc_drv` low only while it is true. `fb_drv` is unaffected.
- R11: `mains_low` forces `pfc_drv` low until `mains_ok` asserts. Clearing `mains_low` alone does not release it.
- R12: Loss of the lockout flag in either run state stops both drives and enters safe restart.
- R13: The latched state is left only by reset or by loss of the trip flag. After that, a normal power-up runs.
- R14: When `flt_latch` and `flt_restart` arrive in the same cycle, the latched response wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| vcc_trip | input | 1 | supply above the trip level |
| vcc_uvlo | input | 1 | supply above the lockout level |
| vcc_hlo | input | 1 | supply above the lower hysteresis threshold |
| vcc_start | input | 1 | supply above the start level (upper threshold) |
| lat_ok | input | 1 | latch pin above its enable level |
| pfc_ss_ok | input | 1 | correction soft-start charged |
| fb_ss_ok | input | 1 | flyback soft-start charged |
| bus_start | input | 1 | bus voltage high enough to start the flyback |
| pfc_ovp | input | 1 | bus overvoltage |
| mains_low | input | 1 | mains below its stop level |
| mains_ok | input | 1 | mains above its restart level |
| ctrl_tmo | input | 1 | flyback control pin timeout |
| flt_latch | input | 1 | latched protection request pulse |
| flt_restart | input | 1 | safe-restart protection request pulse |
| chg_mode | output | 2 | charge current: 00 off, 01 low, 10 high |
| latch_drv | output | 1 | latch-pin drive enable |
| ss_chg | output | 1 | soft-start charging enable |
| pfc_drv | output | 1 | correction gate-drive enable |
| fb_drv | output | 1 | flyback gate-drive enable |

## Verification
Two responses can fall in the same cycle: a latched protection request and a safe-restart request. The bench provokes this by pulsing `flt_latch` and `flt_restart` together on one clock edge while the flyback is running. It then judges the outcome by what follows. The charge current must stay off at a high supply, come on only after the lockout flag drops, and the converters must never restart even when every start condition is true again. A second overlap, an overvoltage pause on top of a running flyback, is checked by confirming that `fb_drv` stays high while `pfc_drv` falls.

// File: rtl/startup_seq.sv
module startup_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_trip,
  input  logic       vcc_uvlo,
  input  logic       vcc_hlo,
  input  logic       vcc_start,
  input  logic       lat_ok,
  input  logic       pfc_ss_ok,
  input  logic       fb_ss_ok,
  input  logic       bus_start,
  input  logic       pfc_ovp,
  input  logic       mains_low,
  input  logic       mains_ok,
  input  logic       ctrl_tmo,
  input  logic       flt_latch,
  input  logic       flt_restart,
  output logic [1:0] chg_mode,
  output logic       latch_drv,
  output logic       ss_chg,
  output logic       pfc_drv,
  output logic       fb_drv
);
  localparam int NIN = 14;
  localparam int IDLE = 0, INIT = 1, PFC = 2, FLY = 3, RSTR = 4, LAT = 5;
  localparam logic [5:0] S_IDLE = 6'b000001;
  localparam logic [5:0] S_INIT = 6'b000010;
  localparam logic [5:0] S_PFC  = 6'b000100;
  localparam logic [5:0] S_FLY  = 6'b001000;
  localparam logic [5:0] S_RSTR = 6'b010000;
  localparam logic [5:0] S_LAT  = 6'b100000;
  localparam logic [1:0] CHG_OFF = 2'b00, CHG_LOW = 2'b01, CHG_HIGH = 2'b10;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync [SYNC_STAGES];
  logic [NIN-1:0] s;

  assign raw = {flt_restart, flt_latch, ctrl_tmo, mains_ok, mains_low, pfc_ovp,
                bus_start, fb_ss_ok, pfc_ss_ok, lat_ok, vcc_start, vcc_hlo,
                vcc_uvlo, vcc_trip};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync[i] <= '0;
    end else begin
      sync[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync[i] <= sync[i-1];
    end
  end
  assign s = sync[SYNC_STAGES-1];

  logic trip_s, uvlo_s, hlo_s, start_s, lat_s, pss_s, fss_s, bus_s;
  logic ovp_s, mlow_s, mok_s, tmo_s, flat_s, frst_s;
  assign {frst_s, flat_s, tmo_s, mok_s, mlow_s, ovp_s, bus_s, fss_s,
          pss_s, lat_s, start_s, hlo_s, uvlo_s, trip_s} = s;

  logic [5:0] st, st_n;
  logic       hyst, hyst_n, hold;
  logic       running;

  assign running = st[INIT] | st[PFC] | st[FLY];

  always_comb begin
    st_n = st;
    if (st[IDLE]) begin
      if (start_s) st_n = S_INIT;
    end else if (running) begin
      if (flat_s)                                   st_n = S_LAT;
      else if (frst_s)                              st_n = S_RSTR;
      else if (st[INIT] && !uvlo_s)                 st_n = S_IDLE;
      else if (!uvlo_s || (st[FLY] && tmo_s))       st_n = S_RSTR;
      else if (st[INIT] && lat_s && pss_s)          st_n = S_PFC;
      else if (st[PFC] && bus_s && fss_s)           st_n = S_FLY;
    end else if (st[RSTR]) begin
      if (!uvlo_s) st_n = S_IDLE;
    end else if (st[LAT]) begin
      if (!trip_s) st_n = S_IDLE;
    end else begin
      st_n = S_IDLE;
    end
  end

  always_comb begin
    hyst_n = 1'b0;
    if (st_n[PFC] && !st[PFC])     hyst_n = 1'b1;
    else if (st[PFC] && st_n[PFC]) hyst_n = start_s ? 1'b0 : (!hlo_s ? 1'b1 : hyst);
    else if (st[LAT] && st_n[LAT]) hyst_n = !uvlo_s ? 1'b1 : (start_s ? 1'b0 : hyst);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      hyst <= 1'b0;
      hold <= 1'b0;
    end else begin
      st   <= st_n;
      hyst <= hyst_n;
      if (mlow_s)     hold <= 1'b1;
      else if (mok_s) hold <= 1'b0;
    end
  end

  always_comb begin
    chg_mode = CHG_OFF;
    if (st[IDLE])             chg_mode = !trip_s ? CHG_LOW : (!uvlo_s ? CHG_HIGH : CHG_LOW);
    else if (st[PFC] | st[LAT]) chg_mode = hyst ? CHG_HIGH : CHG_OFF;
  end

  assign latch_drv = running;
  assign ss_chg    = running;
  assign pfc_drv   = (st[PFC] | st[FLY]) & ~ovp_s & ~hold;
  assign fb_drv    = st[FLY];

  assert_fb_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_drv) |-> $past(fss_s && bus_s)) else $error("flyback started without soft-start");
  assert_fb_charge_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_drv |-> chg_mode == CHG_OFF) else $error("charge on during flyback");
  assert_pfc_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[PFC]) |-> $past(lat_s && pss_s)) else $error("pfc entered without enables");
  assert_pfc_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_drv |-> latch_drv) else $error("pfc drive without latch drive");
  assert_latched_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (st[LAT] && trip_s) |=> st[LAT]) else $error("latched state left");
  assert_latched_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st[LAT] |-> (!pfc_drv && !fb_drv && !latch_drv)) else $error("drive in latched state");
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st[RSTR] |-> (chg_mode == CHG_OFF && !pfc_drv && !fb_drv)) else $error("restart not quiet");
  assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(st)) else $error("state not one-hot");
endmodule

// File: tb/tb_startup_seq.sv
module tb_startup_seq;
  logic clk = 0;
  logic rst_n = 0;
  logic vcc_trip = 0, vcc_uvlo = 0, vcc_hlo = 0, vcc_start = 0;
  logic lat_ok = 0, pfc_ss_ok = 0, fb_ss_ok = 0, bus_start = 0;
  logic pfc_ovp = 0, mains_low = 0, mains_ok = 0, ctrl_tmo = 0;
  logic flt_latch = 0, flt_restart = 0;
  logic [1:0] chg_mode;
  logic latch_drv, ss_chg, pfc_drv, fb_drv;

  always #2.5 clk = ~clk;

  startup_seq dut (.*);

  typedef struct {
    logic [1:0] chg;
    logic l, s, p, f;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic setv(input int lvl);
    @(negedge clk);
    vcc_trip = lvl >= 1; vcc_uvlo = lvl >= 2; vcc_hlo = lvl >= 3; vcc_start = lvl >= 4;
  endtask

  task automatic expect_out(input string tag, input logic [1:0] c,
                            input logic l, input logic s, input logic p, input logic f);
    exp_t e;
    repeat (8) @(posedge clk);
    e.chg = c; e.l = l; e.s = s; e.p = p; e.f = f; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic pulse_latch(input bit lt, input bit rs);
    @(negedge clk); flt_latch = lt; flt_restart = rs;
    @(negedge clk); flt_latch = 0;  flt_restart = 0;
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({chg_mode, latch_drv, ss_chg, pfc_drv, fb_drv} !== {e.chg, e.l, e.s, e.p, e.f}) begin
        fails++;
        $display("FAIL %s: got chg=%b l=%b s=%b p=%b f=%b, expected chg=%b l=%b s=%b p=%b f=%b",
                 e.tag, chg_mode, latch_drv, ss_chg, pfc_drv, fb_drv, e.chg, e.l, e.s, e.p, e.f);
      end
    end
  end

  task automatic go_fly();
    setv(1); expect_out("R7 recharge", 2'b10, 0, 0, 0, 0);
    setv(4); expect_out("R7 full restart reaches flyback", 2'b00, 1, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_out("R1 reset state", 2'b01, 0, 0, 0, 0);
    setv(0); expect_out("R1 below trip", 2'b01, 0, 0, 0, 0);
    setv(1); expect_out("R1 trip band", 2'b10, 0, 0, 0, 0);
    setv(2); expect_out("R1 lockout band", 2'b01, 0, 0, 0, 0);
    setv(4); expect_out("R2 init", 2'b00, 1, 1, 0, 0);
    @(negedge clk); lat_ok = 1;
    expect_out("R3 latch only", 2'b00, 1, 1, 0, 0);
    setv(1); expect_out("R6 init abandon", 2'b10, 0, 0, 0, 0);
    setv(4); expect_out("R2 init again", 2'b00, 1, 1, 0, 0);
    setv(3); expect_out("R2 init hold", 2'b00, 1, 1, 0, 0);
    @(negedge clk); pfc_ss_ok = 1;
    expect_out("R3 pfc start", 2'b10, 1, 1, 1, 0);
    setv(4); expect_out("R5 upper off", 2'b00, 1, 1, 1, 0);
    setv(3); expect_out("R5 band keeps off", 2'b00, 1, 1, 1, 0);
    setv(2); expect_out("R5 lower on", 2'b10, 1, 1, 1, 0);
    setv(3); expect_out("R5 band keeps on", 2'b10, 1, 1, 1, 0);
    @(negedge clk); pfc_ovp = 1;
    expect_out("R10 ovp pause", 2'b10, 1, 1, 0, 0);
    @(negedge clk); pfc_ovp = 0;
    expect_out("R10 ovp release", 2'b10, 1, 1, 1, 0);
    @(negedge clk); mains_low = 1;
    expect_out("R11 mains low", 2'b10, 1, 1, 0, 0);
    @(negedge clk); mains_low = 0;
    expect_out("R11 still held", 2'b10, 1, 1, 0, 0);
    @(negedge clk); mains_ok = 1;
    expect_out("R11 mains ok", 2'b10, 1, 1, 1, 0);
    @(negedge clk); mains_ok = 0;
    @(negedge clk); bus_start = 1;
    expect_out("R4 bus without soft-start", 2'b10, 1, 1, 1, 0);
    @(negedge clk); fb_ss_ok = 1;
    expect_out("R4 flyback start", 2'b00, 1, 1, 1, 1);
    @(negedge clk); pfc_ovp = 1;
    expect_out("R10 ovp with flyback", 2'b00, 1, 1, 0, 1);
    @(negedge clk); pfc_ovp = 0;
    setv(4);
    @(negedge clk); ctrl_tmo = 1;
    expect_out("R7 timeout", 2'b00, 0, 0, 0, 0);
    @(negedge clk); ctrl_tmo = 0;
    go_fly();
    setv(1); expect_out("R12 lockout loss", 2'b10, 0, 0, 0, 0);
    setv(4); expect_out("R12 restart", 2'b00, 1, 1, 1, 1);
    pulse_latch(0, 1);
    expect_out("R8 restart pulse", 2'b00, 0, 0, 0, 0);
    go_fly();
    pulse_latch(1, 1);
    expect_out("R14 latch wins", 2'b00, 0, 0, 0, 0);
    setv(2); expect_out("R9 sag", 2'b00, 0, 0, 0, 0);
    setv(1); expect_out("R9 recharge on", 2'b10, 0, 0, 0, 0);
    setv(4); expect_out("R9 recharge off no restart", 2'b00, 0, 0, 0, 0);
    setv(0); expect_out("R13 power down", 2'b01, 0, 0, 0, 0);
    setv(4); expect_out("R13 restart after power down", 2'b00, 1, 1, 1, 1);
    pulse_latch(1, 0);
    expect_out("R9 latched", 2'b00, 0, 0, 0, 0);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    expect_out("R13 reset leaves latched", 2'b00, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule